// File: doc/BRIEF.md
# Binary Field Inverter

This block returns the multiplicative inverse of an element of GF(2^163) in polynomial basis, with reduction polynomial x^163 + x^7 + x^6 + x^3 + 1. It is meant to sit beside a point multiplier, which hands it an affine conversion or slope denominator. It raises the operand to the power 2^163 - 2, which by Fermat's little theorem is the inverse. The exponent is built along an addition chain over the bits of m - 1 = 162, so one inversion needs 161 squarings, only 9 field multiplications and one last squaring.

Squaring is a purely combinational spread-and-fold that updates the working register in a single cycle. Multiplication is bit-serial with the most significant bit first. Each cycle the partial product is shifted by x and folded back under the polynomial before the next operand term is added, so no separate reduction pass follows. A start pulse with a nonzero operand begins a run of a fixed length. A zero operand produces a done pulse at once, with an error flag and a zero result.

Top module: `gf2m_inverter`

## Requirements
- R1: While reset is applied and afterwards until the first start, busy, done and err are 0 and res is all zeros.
- R2: For any nonzero operand, the res presented with done satisfies res * op = 1 in GF(2^163) modulo x^163 + x^7 + x^6 + x^3 + 1.
- R3: A start taken while idle with op_in equal to zero raises done and err together on the next clock, with res equal to zero. err is never high without done.
- R4: For a nonzero operand with the default field size, done rises exactly 1629 clock edges after the edge that accepts start. This is 161 single-cycle squarings, 9 multiplications of 163 cycles each and 1 final squaring.
- R5: busy is high from the edge that accepts a nonzero start until the edge that raises done, and it is low in the done cycle. done lasts exactly one cycle.
- R6: A start raised while busy is ignored. The run continues with the operand captured first, and its result inverts that operand.
- R7: res changes only on the edge that raises done. Between done pulses it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion of op_in (taken only when idle) |
| op_in | input | 163 | Field element to invert, sampled with start |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle pulse, res valid |
| err | output | 1 | With done: operand was zero |
| res | output | 163 | Inverse of the captured operand |

## Verification
The embedded properties assume that start reaches the block only through the handshake. They assume that the operand needs to be valid only in the cycle start is taken, and that the capture register may be written only from idle. The stimulus presents each operand together with a one-cycle start pulse. It raises further starts only while busy, to probe that they are ignored, and never changes reset during a run. Operands cover 1, x, all-ones, zero and random values. Results are judged by a separate schoolbook multiplier that checks the product equals one.

// File: rtl/gf2m_inverter.sv
module gf2m_inverter #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] op_in,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [M-1:0] res
);

  localparam int CW  = $clog2(M + 1);
  localparam int TOP = $clog2(M) - 1;
  localparam int BW  = (TOP < 2) ? 1 : $clog2(TOP + 1);
  localparam logic [CW-1:0] EXP = CW'(M - 1);

  typedef enum logic [1:0] {S_IDLE, S_SQR, S_MUL, S_FIN} st_t;

  st_t          st;
  logic [M-1:0] acc, sav, x, prod;
  logic [CW-1:0] cnt, k;
  logic [BW-1:0] bi;
  logic          inc;

  function automatic logic [M-1:0] sq(input logic [M-1:0] v);
    logic [2*M-2:0] t;
    t = '0;
    for (int i = 0; i < M; i++) t[2*i] = v[i];
    for (int j = 2*M-2; j >= M; j--)
      if (t[j]) begin
        t[j] = 1'b0;
        t[j-M +: M] = t[j-M +: M] ^ POLY;
      end
    return t[M-1:0];
  endfunction

  function automatic logic [M-1:0] xt(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  wire [M-1:0]  opnd  = inc ? x : sav;
  wire [M-1:0]  pnext = xt(prod) ^ (acc[cnt] ? opnd : '0);
  wire [CW-1:0] knext = inc ? k + CW'(1) : k << 1;
  wire          more  = !inc && EXP[bi];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      acc  <= '0;
      sav  <= '0;
      x    <= '0;
      prod <= '0;
      cnt  <= '0;
      k    <= '0;
      bi   <= '0;
      inc  <= 1'b0;
      res  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (op_in == '0) begin
              done <= 1'b1;
              err  <= 1'b1;
              res  <= '0;
            end else begin
              acc <= op_in;
              sav <= op_in;
              x   <= op_in;
              k   <= CW'(1);
              cnt <= CW'(1);
              bi  <= BW'(TOP - 1);
              inc <= 1'b0;
              st  <= S_SQR;
            end
          end
        S_SQR: begin
          acc <= sq(acc);
          if (cnt == CW'(1)) begin
            cnt  <= CW'(M - 1);
            prod <= '0;
            st   <= S_MUL;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_MUL: begin
          prod <= pnext;
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else begin
            acc <= pnext;
            sav <= pnext;
            k   <= knext;
            if (more) begin
              inc <= 1'b1;
              cnt <= CW'(1);
              st  <= S_SQR;
            end else if (bi == '0) begin
              st <= S_FIN;
            end else begin
              bi  <= bi - BW'(1);
              inc <= 1'b0;
              cnt <= knext;
              st  <= S_SQR;
            end
          end
        end
        S_FIN: begin
          res  <= sq(acc);
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (done && res == '0)); // R3
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(x)); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(res)); // R7
  AST_CHAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (k != '0 && int'(k) <= M - 1)); // R4
  AST_SQR_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (st == S_SQR) |-> (cnt != '0 && cnt <= k)); // R4

endmodule

// File: tb/gf2m_inverter_test.sv
`timescale 1ns/1ps
module gf2m_inverter_test;
  localparam int M = 163;
  localparam int LAT = 1629;
  localparam logic [2*M-2:0] FULLPOLY = (2*M-1)'('hC9);

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] op_in = '0;
  logic busy, done, err;
  logic [M-1:0] res;

  always #2 clk = ~clk;

  gf2m_inverter uut (.clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
                     .busy(busy), .done(done), .err(err), .res(res));

  int checks = 0, fails = 0;
  bit finished = 0;
  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_cnt = 0;
  logic [M-1:0] m_op = '0, last_res = '0;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-2:0] p;
    p = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) p = p ^ ((2*M-1)'(a) << i);
    for (int j = 2*M-2; j >= M; j--)
      if (p[j]) p = p ^ (((2*M-1)'(1) << j) | (FULLPOLY << (j - M)));
    return p[M-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      m_err = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        if (op_in == '0) begin
          m_done = 1;
          m_err = 1;
        end else begin
          m_busy = 1;
          m_cnt = LAT;
          m_op = op_in;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({busy, done, err} == {m_busy, m_done, m_err}, "R4/R5/R3", "busy,done,err",
            M'({busy, done, err}), M'({m_busy, m_done, m_err}));
      if (m_done) begin
        if (m_err) check(res == '0, "R3", "zero operand result", res, '0);
        else check(ref_mul(res, m_op) == M'(1), "R2/R6", "res*op", ref_mul(res, m_op), M'(1));
        last_res = res;
      end else begin
        check(res == last_res, "R7", "res held", res, last_res);
      end
    end
  end

  task automatic run_inv(input logic [M-1:0] op);
    @(negedge clk);
    start = 1;
    op_in = op;
    @(negedge clk);
    start = 0;
    op_in = '0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [M-1:0] rnd();
    logic [191:0] r;
    r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    if (r[M-1:0] == '0) r[0] = 1'b1;
    return r[M-1:0];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, err} == 3'b000, "R1", "flags in reset", M'({busy, done, err}), '0);
    check(res == '0, "R1", "res in reset", res, '0);
    rst_n = 1;
    @(negedge clk);
    check({busy, done, err} == 3'b000 && res == '0, "R1", "idle after reset", res, '0);

    run_inv(M'(1));
    run_inv(M'(2));
    run_inv('1);
    run_inv('0);
    for (int n = 0; n < 6; n++) run_inv(rnd());

    // R6: starts raised during a run must be ignored
    @(negedge clk);
    start = 1;
    op_in = rnd();
    @(negedge clk);
    op_in = rnd();
    repeat (5) @(negedge clk);
    op_in = '0;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);

    run_inv('0);
    run_inv(rnd());
    repeat (4) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual busy=%0d expected done", busy);
      finish_up();
    end
  end
endmodule